// File: doc/BRIEF.md
# Dual-Output Encoded Clock Divider

This block produces two output clock enables from one fast input clock. A 3-bit ratio code and a 1-bit pairing control select the divide ratio. Each output is a single-cycle enable pulse that recurs once every N input cycles. The ratio map is deliberately irregular: it is neither linear nor monotonic in the code, and it includes divide by 6 and divide by 12.

With pairing off, both outputs run at the same ratio and pulse together. With pairing on, output B runs at half the rate of output A. It pulses on every second A pulse, so the two stay phase-aligned.

A code that is not supported for the current pairing setting stops both outputs and raises an error flag. A separate reference-enable output divides the input clock by 2 or by 4 under a pre-divider select.

All changes to the codes are applied only at a terminal count, so a period is never cut short. Downstream logic uses these enables to clock-gate or to step slower domains.

Top module: `dual_ratio_divider`

## Requirements
- R1: Reset (`rst`, synchronous, active high) holds every enable low and samples the codes present at the reset edge. The first A pulse appears exactly N cycles after the last reset edge, where N is the ratio of the sampled code.
- R2: With `nb_pair` = 0, the A ratio is selected by `na_code` as follows: 3'b000 gives 2, 3'b001 gives 32, 3'b010 gives 8, 3'b011 gives 12, 3'b100 gives 4, 3'b101 gives 6 and 3'b110 gives 16.
- R3: With `nb_pair` = 0, `qb_en` pulses in exactly the same cycles as `qa_en`.
- R4: With `nb_pair` = 1, the A ratio is 2, 8, 4, 6 or 16 for the codes 3'b000, 3'b010, 3'b100, 3'b101 and 3'b110. `qb_en` pulses only together with `qa_en`, on every second A pulse, which gives B twice the A ratio.
- R5: The code 3'b111 (for either `nb_pair` value) and the codes 3'b001 and 3'b011 (with `nb_pair` = 1) are illegal. Once an illegal code is in force, `code_err` is high and `qa_en` and `qb_en` stay low.
- R6: Every enable pulse lasts exactly one input clock cycle.
- R7: A new code is taken up only at the A terminal count. The period in progress always completes at its old length. An illegal code in force is replaced by a legal one at the next clock edge.
- R8: `ref_en` pulses once every 2 cycles when `pre_sel` = 0 and once every 4 cycles when `pre_sel` = 1. A change of `pre_sel` takes effect at the next `ref_en` terminal count.
- R9: Each time pairing begins, whether from reset, from `nb_pair` = 0 or from an illegal code, the first B pulse falls on the second A pulse of the new setting. A change between two paired codes keeps the existing A/B alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| na_code | input | 3 | Ratio code |
| nb_pair | input | 1 | Pairing control: B at half the A rate when 1 |
| pre_sel | input | 1 | Reference divide select: 0 gives /2, 1 gives /4 |
| qa_en | output | 1 | Output A enable pulse |
| qb_en | output | 1 | Output B enable pulse |
| ref_en | output | 1 | Reference enable pulse |
| code_err | output | 1 | Illegal code in force |

## Verification
Two functions can fall in the same cycle: a code change presented on the terminal-count cycle, which must be taken up by the reload on that edge, and the coincident A and B pulses in both pairing modes. The bench provokes the first by tracking its own model of the period and changing the inputs exactly in the terminal cycle. It also changes the inputs mid-period, to show that the old period completes. A scoreboard model, written from the ratio table and the alternation rule, predicts all four outputs in every cycle. Each prediction is compared with the design's outputs one cycle later.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned CODE_W  = 3;
    localparam int unsigned MAX_DIV = 32;
    localparam int unsigned CNT_W   = $clog2(MAX_DIV);
    localparam int unsigned PRE_LO  = 2;
    localparam int unsigned PRE_HI  = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [CODE_W-1:0] {
        CODE_D2  = 3'b000,
        CODE_D32 = 3'b001,
        CODE_D8  = 3'b010,
        CODE_D12 = 3'b011,
        CODE_D4  = 3'b100,
        CODE_D6  = 3'b101,
        CODE_D16 = 3'b110,
        CODE_BAD = 3'b111
    } ratio_code_e;

    typedef struct packed {
        logic legal;
        logic paired;
        cnt_t reload;
    } div_cfg_t;

    function automatic int unsigned code_ratio(input logic [CODE_W-1:0] code);
        case (ratio_code_e'(code))
            CODE_D2:  return 2;
            CODE_D32: return 32;
            CODE_D8:  return 8;
            CODE_D12: return 12;
            CODE_D4:  return 4;
            CODE_D6:  return 6;
            CODE_D16: return 16;
            default:  return 1;
        endcase
    endfunction

    function automatic logic code_legal(input logic [CODE_W-1:0] code, input logic pair);
        logic ok;
        ok = (ratio_code_e'(code) != CODE_BAD);
        if (pair && (ratio_code_e'(code) == CODE_D32 || ratio_code_e'(code) == CODE_D12))
            ok = 1'b0;
        return ok;
    endfunction

    function automatic div_cfg_t decode_cfg(input logic [CODE_W-1:0] code, input logic pair);
        div_cfg_t c;
        c.legal  = code_legal(code, pair);
        c.paired = c.legal & pair;
        c.reload = c.legal ? cnt_t'(code_ratio(code) - 1) : '0;
        return c;
    endfunction

    function automatic cnt_t pre_reload(input logic sel);
        return sel ? cnt_t'(PRE_HI - 1) : cnt_t'(PRE_LO - 1);
    endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              pair,
    output div_cfg_t          cfg
);
    always_comb cfg = decode_cfg(code, pair);
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] load_val,
    output logic             tc
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == '0)
            cnt_q <= load_val;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tc = (cnt_q == '0);

    p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
        !tc |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/clkdiv_pair_phase.sv
module clkdiv_pair_phase (
    input  logic clk,
    input  logic rst,
    input  logic tc,
    input  logic cur_legal,
    input  logic cur_paired,
    input  logic next_paired,
    output logic qb_pulse
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst)
            half_q <= 1'b0;
        else if (tc)
            half_q <= next_paired & cur_paired & ~half_q;
    end

    assign qb_pulse = tc & cur_legal & (cur_paired ? half_q : 1'b1);

    p_half_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (tc && !cur_paired) |=> !half_q);
endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] na_code,
    input  logic              nb_pair,
    input  logic              pre_sel,
    output logic              qa_en,
    output logic              qb_en,
    output logic              ref_en,
    output logic              code_err
);
    div_cfg_t next_cfg;
    div_cfg_t cfg_q;
    logic     main_tc;
    logic     pre_tc;
    logic     qb_pulse;

    clkdiv_decode u_dec (
        .code (na_code),
        .pair (nb_pair),
        .cfg  (next_cfg)
    );

    clkdiv_counter #(.WIDTH(CNT_W)) u_main_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_val (next_cfg.reload),
        .tc       (main_tc)
    );

    always_ff @(posedge clk) begin
        if (rst || main_tc)
            cfg_q <= next_cfg;
    end

    clkdiv_pair_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .tc          (main_tc),
        .cur_legal   (cfg_q.legal),
        .cur_paired  (cfg_q.paired),
        .next_paired (next_cfg.paired),
        .qb_pulse    (qb_pulse)
    );

    clkdiv_counter #(.WIDTH(CNT_W)) u_pre_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_val (pre_reload(pre_sel)),
        .tc       (pre_tc)
    );

    assign qa_en    = main_tc & cfg_q.legal;
    assign qb_en    = qb_pulse;
    assign ref_en   = pre_tc;
    assign code_err = ~cfg_q.legal;

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        code_err |-> (!qa_en && !qb_en));
    p_qb_with_qa_r4: assert property (@(posedge clk) disable iff (rst)
        qb_en |-> qa_en);
    p_qa_single_r6: assert property (@(posedge clk) disable iff (rst)
        qa_en |=> !qa_en);
    p_ref_single_r8: assert property (@(posedge clk) disable iff (rst)
        ref_en |=> !ref_en);
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !main_tc |=> $stable(cfg_q));
endmodule

// File: tb/dual_ratio_divider_test.sv
module dual_ratio_divider_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] na_code = 3'b000;
    logic       nb_pair = 1'b0;
    logic       pre_sel = 1'b0;
    logic       qa_en, qb_en, ref_en, code_err;

    always #4 clk = ~clk;

    dual_ratio_divider uut (
        .clk(clk), .rst(rst), .na_code(na_code), .nb_pair(nb_pair),
        .pre_sel(pre_sel), .qa_en(qa_en), .qb_en(qb_en),
        .ref_en(ref_en), .code_err(code_err)
    );

    typedef struct {
        logic  qa, qb, rf, er;
        string tag_a, tag_b;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;

    // scoreboard model state
    int m_ratio = 1, m_age = 1, m_n = 0;
    bit m_legal = 1'b0, m_nb = 1'b0;
    int r_ratio = 2, r_age = 1;

    function automatic int tb_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 2;  3'd1: return 32; 3'd2: return 8;  3'd3: return 12;
            3'd4: return 4;  3'd5: return 6;  3'd6: return 16; default: return 1;
        endcase
    endfunction

    task automatic model_load(input logic [2:0] c, input logic nb, input bit rv);
        bit legal, was_pair, now_pair;
        legal    = !(c == 3'd7 || (nb && (c == 3'd1 || c == 3'd3)));
        was_pair = m_legal && m_nb;
        now_pair = legal && nb;
        if (rv || !was_pair || !now_pair) m_n = 0; else m_n = m_n + 1;
        m_legal = legal;
        m_nb    = nb;
        m_ratio = legal ? tb_ratio(c) : 1;
        m_age   = 1;
    endtask

    task automatic step(input bit rv, input logic [2:0] c, input logic nb,
                        input logic p, input string tag);
        exp_t e;
        @(negedge clk);
        rst = rv; na_code = c; nb_pair = nb; pre_sel = p;
        @(posedge clk);
        if (rv || m_age == m_ratio) model_load(c, nb, rv); else m_age = m_age + 1;
        if (rv || r_age == r_ratio) begin r_ratio = p ? 4 : 2; r_age = 1; end
        else r_age = r_age + 1;
        e.qa = m_legal && (m_age == m_ratio);
        e.qb = e.qa && (!m_nb || (m_n % 2 == 1));
        e.rf = (r_age == r_ratio);
        e.er = !m_legal;
        e.tag_a = tag;
        e.tag_b = (tag == "R9") ? "R9" : (m_nb ? "R4" : "R3");
        exp_q.push_back(e);
    endtask

    task automatic run(input logic [2:0] c, input logic nb, input logic p,
                       input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, c, nb, p, tag);
    endtask

    // step until the model is in a terminal-count cycle
    task automatic to_terminal(input logic [2:0] c, input logic nb, input string tag);
        for (int i = 0; i < 40 && m_age != m_ratio; i++) step(1'b0, c, nb, 1'b0, tag);
    endtask

    task automatic cmp(input logic act, input logic expv, input string what,
                       input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, expv, $time);
        end
    endtask

    // monitor: compare one cycle after each prediction
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp(qa_en,    e.qa, "qa_en",    e.tag_a);
            cmp(qb_en,    e.qb, "qb_en",    e.tag_b);
            cmp(ref_en,   e.rf, "ref_en",   "R8");
            cmp(code_err, e.er, "code_err", "R5");
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and first pulse timing
        for (int i = 0; i < 3; i++) step(1'b1, 3'd0, 1'b0, 1'b0, "R1");
        run(3'd0, 1'b0, 1'b0, 8, "R1");
        for (int i = 0; i < 2; i++) step(1'b1, 3'd2, 1'b0, 1'b0, "R1");
        run(3'd2, 1'b0, 1'b0, 20, "R1");
        // R2: ratio table, pairing off
        for (int c = 0; c < 7; c++) run(3'(c), 1'b0, 1'b0, 70, "R2");
        // R6: shortest ratio, pulses must stay one cycle wide
        run(3'd0, 1'b1, 1'b0, 20, "R6");
        // R4: paired ratios
        run(3'd2, 1'b0, 1'b0, 10, "R4");
        run(3'd0, 1'b1, 1'b0, 40, "R4");
        run(3'd2, 1'b1, 1'b0, 70, "R4");
        run(3'd4, 1'b1, 1'b0, 40, "R4");
        run(3'd5, 1'b1, 1'b0, 50, "R4");
        run(3'd6, 1'b1, 1'b0, 80, "R4");
        // R5: illegal codes, then recovery (R7)
        run(3'd1, 1'b1, 1'b0, 40, "R5");
        run(3'd0, 1'b0, 1'b0, 6, "R7");
        run(3'd3, 1'b1, 1'b0, 14, "R5");
        run(3'd7, 1'b1, 1'b0, 10, "R5");
        run(3'd7, 1'b0, 1'b0, 10, "R5");
        run(3'd4, 1'b0, 1'b0, 12, "R7");
        // R7: mid-period change, the old period completes
        run(3'd6, 1'b0, 1'b0, 5, "R7");
        run(3'd0, 1'b0, 1'b0, 30, "R7");
        // R7: change presented exactly in the terminal cycle
        for (int k = 0; k < 4; k++) begin
            to_terminal(3'(k + 2), 1'b0, "R7");
            run(3'(k + 3), 1'b0, 1'b0, 1, "R7");
            run(3'(k + 3), 1'b0, 1'b0, 25, "R7");
        end
        // R9: pairing start from unpaired, from illegal, and paired-to-paired
        run(3'd4, 1'b0, 1'b0, 12, "R9");
        run(3'd4, 1'b1, 1'b0, 40, "R9");
        run(3'd2, 1'b1, 1'b0, 50, "R9");
        to_terminal(3'd2, 1'b1, "R9");
        run(3'd5, 1'b1, 1'b0, 40, "R9");
        run(3'd7, 1'b1, 1'b0, 8, "R9");
        run(3'd0, 1'b1, 1'b0, 20, "R9");
        // R8: reference divider select, including mid-period toggles
        run(3'd0, 1'b0, 1'b1, 20, "R8");
        for (int i = 0; i < 12; i++) run(3'd0, 1'b0, 1'(i % 2), 3, "R8");
        run(3'd0, 1'b0, 1'b0, 10, "R8");
        // drain the scoreboard
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule